// File: doc/BRIEF.md
# Write-Enable Qualifier with Inhibit

This block sits between the control-pin decoder and the self-timed write engine of a byte-wide nonvolatile memory. It watches the synchronized chip-enable, output-enable and write-enable levels (all active low) and a digital supply-good flag from an external comparator. It issues a single-cycle write-start pulse only when every protection condition allows one. The analog comparator itself lies outside the block.

Three guards are combined into one gate. First, a minimum-width filter rejects write strobes shorter than a set number of clocks. Second, a power-up hold-off timer keeps writes locked until the supply has been good for a set number of clocks, and it restarts on every supply drop. Third, writes are locked out whenever supply-good is low or the control levels do not request a write. A combinational status flag reports whether a write would be blocked right now.

The write-request level is chip-enable low, write-enable low and output-enable high. A strobe is consumed when it reaches the qualifying length, whether or not it fires. Another pulse needs the strobe to be released first.

Top module: `wr_gate_qualifier`

## Requirements
- R1: While `rst` is sampled high, `wr_start` is low in the following cycle. After reset, `wr_inhibit` is high until the hold-off has elapsed.
- R2: While `supply_ok` is low, `wr_inhibit` is high. Any clock edge at which `supply_ok` is low produces no `wr_start` in the following cycle.
- R3: Writes unlock only after `supply_ok` has been sampled high on `POWERUP_CYCLES` consecutive clock edges. A strobe that qualifies before then produces no pulse.
- R4: A supply drop of any length, even a single cycle, restarts the hold-off count from zero.
- R5: No pulse is produced while the control levels request inhibit, meaning `oe_n` is low, `ce_n` is high or `we_n` is high.
- R6: A write-request level held for fewer than `GLITCH_CYCLES` consecutive clock edges produces no pulse.
- R7: A write-request level held for `GLITCH_CYCLES` consecutive edges, while unlocked, raises `wr_start` for exactly one cycle. That cycle is the one after the `GLITCH_CYCLES`-th edge.
- R8: A strobe yields at most one pulse however long it is held. A new pulse requires the request level to be absent on at least one edge first.
- R9: A strobe that reaches the qualifying length while writes are locked is discarded. It does not fire later if the lock clears while the strobe is still held.
- R10: `wr_inhibit` is high exactly when the hold-off is not complete, or `supply_ok` is low, or the present control levels are not the write-request level. It follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Synchronized chip-enable level, active low |
| oe_n | input | 1 | Synchronized output-enable level, active low |
| we_n | input | 1 | Synchronized write-enable level, active low |
| supply_ok | input | 1 | Digital supply-good flag from the external comparator |
| wr_start | output | 1 | Registered single-cycle qualified write-start pulse |
| wr_inhibit | output | 1 | High when a write is currently blocked |

## Verification
`wr_start` is registered, so a strobe first sampled at edge 1 is due in the cycle after edge `GLITCH_CYCLES`. The unlock from the hold-off timer follows the `POWERUP_CYCLES`-th consecutive good-supply edge, with one register stage on the way. `wr_inhibit` is combinational, so it is due within the same cycle as any input change. The bench changes inputs on the falling edge and advances a requirement-level expected model at each rising edge. It then compares both outputs at the next falling edge, so every check samples one full register stage after the edge that caused it. Pulse counts per directed phase add checks for the discard, glitch and one-per-strobe cases.

// File: rtl/wrq_pkg.sv
package wrq_pkg;

    // Raw control levels as they arrive from the pin synchronizers (active low).
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } ctl_pins_t;

    // Strobe tracker: armed waits for a qualifying strobe, spent waits for release.
    typedef enum logic [0:0] {
        STB_ARMED = 1'b0,
        STB_SPENT = 1'b1
    } stb_state_t;

    // Conditions that must all be true for a write to pass the gate.
    typedef struct packed {
        logic pwr_ready;
        logic supply_ok;
        logic lvl_write;
    } gate_cond_t;

    // Counter width able to hold values 0 .. n-1, never narrower than one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // The only level combination that asks for a write.
    function automatic logic pins_request_write(input ctl_pins_t p);
        return (!p.ce_n) && (!p.we_n) && p.oe_n;
    endfunction

    function automatic logic gate_open(input gate_cond_t c);
        return c.pwr_ready && c.supply_ok && c.lvl_write;
    endfunction

endpackage

// File: rtl/wrq_level_decode.sv
module wrq_level_decode
    import wrq_pkg::*;
(
    input  ctl_pins_t pins,
    output logic      lvl_write
);

    always_comb begin
        lvl_write = pins_request_write(pins);
    end

endmodule

// File: rtl/wrq_powerup_timer.sv
module wrq_powerup_timer
    import wrq_pkg::*;
#(
    parameter int HOLD_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic pwr_ready
);

    localparam int CW = idx_width(HOLD_CYCLES);

    generate
        if (HOLD_CYCLES == 0) begin : g_no_hold
            assign pwr_ready = 1'b1;
        end else begin : g_hold
            logic [CW-1:0] cnt_q;
            logic          ready_q;

            always_ff @(posedge clk) begin
                if (rst || !supply_ok) begin
                    cnt_q   <= '0;
                    ready_q <= 1'b0;
                end else if (!ready_q) begin
                    if (cnt_q == CW'(HOLD_CYCLES - 1)) begin
                        ready_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end

            assign pwr_ready = ready_q;
        end
    endgenerate

endmodule

// File: rtl/wrq_strobe_filter.sv
module wrq_strobe_filter
    import wrq_pkg::*;
#(
    parameter int MIN_LOW = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl_write,
    input  logic allow,
    output logic start
);

    localparam int RW = idx_width(MIN_LOW);

    stb_state_t state_q;
    logic       start_q;
    logic       reach;

    generate
        if (MIN_LOW <= 1) begin : g_single
            assign reach = 1'b1;
        end else begin : g_count
            logic [RW-1:0] run_q;

            always_ff @(posedge clk) begin
                if (rst || !lvl_write) begin
                    run_q <= '0;
                end else if (state_q == STB_ARMED && run_q != RW'(MIN_LOW - 1)) begin
                    run_q <= run_q + 1'b1;
                end
            end

            assign reach = (run_q == RW'(MIN_LOW - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STB_ARMED;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (!lvl_write) begin
                state_q <= STB_ARMED;
            end else if (state_q == STB_ARMED && reach) begin
                state_q <= STB_SPENT;
                start_q <= allow;
            end
        end
    end

    assign start = start_q;

endmodule

// File: rtl/wr_gate_qualifier.sv
module wr_gate_qualifier
    import wrq_pkg::*;
#(
    parameter int GLITCH_CYCLES  = 3,
    parameter int POWERUP_CYCLES = 625000
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic supply_ok,
    output logic wr_start,
    output logic wr_inhibit
);

    ctl_pins_t  pins;
    gate_cond_t cond;
    logic       lvl_write;
    logic       pwr_ready;

    assign pins = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

    wrq_level_decode u_decode (
        .pins      (pins),
        .lvl_write (lvl_write)
    );

    wrq_powerup_timer #(
        .HOLD_CYCLES (POWERUP_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .pwr_ready (pwr_ready)
    );

    assign cond = '{pwr_ready: pwr_ready, supply_ok: supply_ok, lvl_write: lvl_write};

    wrq_strobe_filter #(
        .MIN_LOW (GLITCH_CYCLES)
    ) u_filter (
        .clk       (clk),
        .rst       (rst),
        .lvl_write (lvl_write),
        .allow     (cond.pwr_ready && cond.supply_ok),
        .start     (wr_start)
    );

    assign wr_inhibit = !gate_open(cond);

endmodule

// File: rtl/wrq_checker.sv
module wrq_checker #(
    parameter int GLITCH_CYCLES  = 3,
    parameter int POWERUP_CYCLES = 625000
) (
    input logic clk,
    input logic rst,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic supply_ok,
    input logic wr_start,
    input logic wr_inhibit
);

    localparam int RW = $clog2(GLITCH_CYCLES + 2);
    localparam int UW = $clog2(POWERUP_CYCLES + 2);

    logic          lvl;
    logic [RW-1:0] run_q;
    logic [UW-1:0] up_q;
    logic          seen_q;

    assign lvl = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            up_q   <= '0;
            seen_q <= 1'b0;
        end else begin
            if (!lvl) begin
                run_q <= '0;
            end else if (run_q != RW'(GLITCH_CYCLES)) begin
                run_q <= run_q + 1'b1;
            end
            if (!supply_ok) begin
                up_q <= '0;
            end else if (up_q != UW'(POWERUP_CYCLES + 1)) begin
                up_q <= up_q + 1'b1;
            end
            if (!lvl) begin
                seen_q <= 1'b0;
            end else if (wr_start) begin
                seen_q <= 1'b1;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !wr_start);
    // R2
    supply_flag_chk: assert property (@(posedge clk) disable iff (rst) !supply_ok |-> wr_inhibit);
    // R2
    supply_block_chk: assert property (@(posedge clk) disable iff (rst) !supply_ok |=> !wr_start);
    // R3
    holdoff_chk: assert property (@(posedge clk) disable iff (rst) wr_start |-> (up_q > UW'(POWERUP_CYCLES)));
    // R5
    ctl_inhibit_chk: assert property (@(posedge clk) disable iff (rst) (!oe_n || ce_n || we_n) |-> wr_inhibit);
    // R6
    glitch_chk: assert property (@(posedge clk) disable iff (rst) wr_start |-> (run_q >= RW'(GLITCH_CYCLES)));
    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst) wr_start |=> !wr_start);
    // R8
    one_per_strobe_chk: assert property (@(posedge clk) disable iff (rst) wr_start |-> !seen_q);

endmodule

bind wr_gate_qualifier wrq_checker #(
    .GLITCH_CYCLES  (GLITCH_CYCLES),
    .POWERUP_CYCLES (POWERUP_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .supply_ok  (supply_ok),
    .wr_start   (wr_start),
    .wr_inhibit (wr_inhibit)
);

// File: tb/wr_gate_qualifier_test.sv
module wr_gate_qualifier_test;

    localparam int G = 3;
    localparam int P = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1;
    logic oe_n = 1'b1;
    logic we_n = 1'b1;
    logic supply_ok = 1'b0;
    logic wr_start;
    logic wr_inhibit;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit finished = 1'b0;

    // expected-state model built from the requirements
    int m_up = 0;
    int m_run = 0;
    bit m_spent = 1'b0;
    bit m_start = 1'b0;

    always #4 clk = ~clk;

    wr_gate_qualifier #(
        .GLITCH_CYCLES  (G),
        .POWERUP_CYCLES (P)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .supply_ok  (supply_ok),
        .wr_start   (wr_start),
        .wr_inhibit (wr_inhibit)
    );

    function automatic bit want_write(bit ce, bit oe, bit we);
        return !ce && !we && oe;
    endfunction

    function automatic bit want_inhibit(int up, bit sup, bit lvl);
        return !((up >= P) && sup && lvl);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit lvl = want_write(ce_n, oe_n, we_n);
        bit ready = (m_up >= P);
        if (rst) begin
            m_up = 0; m_run = 0; m_spent = 1'b0; m_start = 1'b0;
        end else begin
            m_start = lvl && !m_spent && (m_run == G - 1) && ready && supply_ok;
            if (!lvl) begin
                m_run = 0; m_spent = 1'b0;
            end else if (!m_spent) begin
                if (m_run == G - 1) m_spent = 1'b1;
                else m_run++;
            end
            m_up = supply_ok ? ((m_up < P) ? m_up + 1 : P) : 0;
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (wr_start) pulses++;
        check(tag, wr_start, m_start);
        check("R10", wr_inhibit, want_inhibit(m_up, supply_ok, want_write(ce_n, oe_n, we_n)));
    endtask

    task automatic hold(int n, string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic set_ctl(bit ce, bit oe, bit we);
        ce_n = ce; oe_n = oe; we_n = we;
    endtask

    task automatic idle(); set_ctl(1'b1, 1'b1, 1'b1); endtask
    task automatic wr_lvl(); set_ctl(1'b0, 1'b1, 1'b0); endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1: watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd5219);
        @(negedge clk);
        hold(2, "R1");
        check("R1", wr_start, 0);
        check("R1", wr_inhibit, 1);
        rst = 1'b0;
        hold(2, "R1");
        check("R1", wr_inhibit, 1);

        // hold-off, and a strobe that qualifies inside it (R3, R9)
        supply_ok = 1'b1;
        hold(P - 5, "R3");
        pulses = 0;
        wr_lvl();
        hold(10, "R9");
        check("R9", pulses, 0);
        check("R3", wr_inhibit, 0);
        idle();
        hold(2, "R3");
        check("R10", wr_inhibit, 1);

        // glitch shorter than the filter (R6)
        pulses = 0;
        wr_lvl();
        hold(G - 1, "R6");
        idle();
        hold(3, "R6");
        check("R6", pulses, 0);

        // qualifying strobe (R7) held long (R8)
        pulses = 0;
        wr_lvl();
        hold(G, "R7");
        check("R7", wr_start, 1);
        step("R7");
        check("R7", wr_start, 0);
        hold(8, "R8");
        check("R8", pulses, 1);
        idle();
        step("R8");
        wr_lvl();
        hold(G + 2, "R8");
        check("R8", pulses, 2);
        idle();
        hold(2, "R8");

        // control levels that inhibit (R5)
        pulses = 0;
        set_ctl(1'b0, 1'b0, 1'b0); hold(6, "R5");
        check("R5", wr_inhibit, 1);
        set_ctl(1'b1, 1'b1, 1'b0); hold(6, "R5");
        set_ctl(1'b0, 1'b1, 1'b1); hold(6, "R5");
        check("R5", pulses, 0);
        idle();
        hold(1, "R5");

        // one-cycle supply drop restarts hold-off (R2, R4)
        supply_ok = 1'b0;
        step("R2");
        check("R2", wr_inhibit, 1);
        supply_ok = 1'b1;
        pulses = 0;
        wr_lvl();
        hold(G + 2, "R4");
        idle();
        hold(P - G - 4, "R4");
        check("R4", pulses, 0);
        hold(4, "R4");
        wr_lvl();
        hold(G + 1, "R4");
        check("R4", pulses, 1);
        idle();
        hold(1, "R4");

        // strobe while supply low (R2)
        pulses = 0;
        supply_ok = 1'b0;
        wr_lvl();
        hold(G + 3, "R2");
        check("R2", pulses, 0);
        idle();
        supply_ok = 1'b1;
        hold(P + 2, "R3");

        // constrained random traffic
        for (int b = 0; b < 1200; b++) begin
            int unsigned pick = $urandom % 4;
            int dur = 1 + int'($urandom % 7);
            supply_ok = (($urandom % 40) != 0);
            if (pick < 2) wr_lvl();
            else if (pick == 2) idle();
            else set_ctl(1'($urandom), 1'($urandom), 1'($urandom));
            hold(dur, "R8");
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule